// File: doc/BRIEF.md
# GPIO Bank Level Interrupt Unit

This block produces one level interrupt for a bank of general purpose input pins. Each pin enters through a two-flop synchronizer. The synchronized value is compared against a programmable polarity bit and gated by an enable bit. While any enabled pin sits at its trigger level, the bank interrupt stays high. No pending state is latched. Software clears the cause by changing the pin, its polarity bit or its enable bit.

A small synchronous register bus serves the bank. The polarity word is a plain read/write register, so software can update it with read-modify-write. The enable word is changed atomically through two write-only strobes, one that sets bits and one that clears them, and it can be read back. The synchronized pin levels can also be read. Read data is registered and appears one cycle after the address.

Top module: `gpio_lvl_irq_bank`

## Requirements
- R1: After reset, irq_o is 0 and the polarity and enable registers read as 0, so every pin is disabled.
- R2: Each pin passes through two flops. The pin-level register (address 0) returns the level the pin had two clock edges before the read address was sampled.
- R3: A polarity bit of 0 makes its pin active when the pin is high. A polarity bit of 1 makes it active when the pin is low.
- R4: The bank interrupt is the OR over pins of (synchronized pin XOR polarity) AND enable. It is registered, so irq_o rises on the third clock edge after a pin input change.
- R5: Writing address 3 sets every enable bit whose write-data bit is 1. Enable bits written as 0 keep their value.
- R6: Writing address 4 clears every enable bit whose write-data bit is 1. Bits written as 0 keep their value, and a cleared active pin stops driving irq_o one edge after the write.
- R7: Address 1 holds the polarity word. A write replaces it, and a read returns the value written.
- R8: Address 2 returns the enable word. Addresses 3 to 7 read as 0.
- R9: The interrupt is level-sensitive with nothing latched. irq_o falls on the third edge after an active pin returns to its idle level.
- R10: rdata_o shows the register selected by addr_i at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Asynchronous pin levels |
| addr_i | input | 3 | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | NUM_PINS | Write data |
| rdata_o | output | NUM_PINS | Registered read data |
| irq_o | output | 1 | Bank level interrupt |

## Verification
A pin change reaches the pin-level register after two edges and irq_o after three. A register write takes effect on the next edge, and irq_o follows one edge after that. Read data is due one edge after the address. The bench drives inputs and samples outputs on falling edges. For latency checks it counts exactly two and three falling edges after a pin change, and checks that irq_o is still low at two and high at three. For static vectors it waits four edges so that every stage has settled.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;
    localparam int unsigned ADDR_W = 3;
    localparam logic [ADDR_W-1:0] ADR_PINS = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_POL  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_EN   = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_ESET = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_ECLR = 3'd4;
endpackage

// File: rtl/gpio_lvl_sync.sv
module gpio_lvl_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '0;
            else         chain_q <= chain_d;
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/gpio_lvl_regs.sv
module gpio_lvl_regs
    import gpio_lvl_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [W-1:0]      pins_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [W-1:0]      wdata_i,
    output logic [W-1:0]      rdata_o,
    output logic [W-1:0]      pol_o,
    output logic [W-1:0]      en_o
);
    typedef struct packed {
        logic [W-1:0] pol;
        logic [W-1:0] en;
        logic [W-1:0] rdata;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we_i) begin
            unique case (addr_i)
                ADR_POL:  regs_d.pol = wdata_i;
                ADR_ESET: regs_d.en  = regs_q.en | wdata_i;
                ADR_ECLR: regs_d.en  = regs_q.en & ~wdata_i;
                default:  ;
            endcase
        end
        unique case (addr_i)
            ADR_PINS: regs_d.rdata = pins_i;
            ADR_POL:  regs_d.rdata = regs_q.pol;
            ADR_EN:   regs_d.rdata = regs_q.en;
            default:  regs_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    assign rdata_o = regs_q.rdata;
    assign pol_o   = regs_q.pol;
    assign en_o    = regs_q.en;

    assert_en_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == ADR_ESET) |=> ((en_o & $past(wdata_i)) == $past(wdata_i)));

    assert_en_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!we_i || (addr_i != ADR_ESET && addr_i != ADR_ECLR)) |=> $stable(en_o));

    assert_en_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == ADR_ECLR) |=> ((en_o & $past(wdata_i)) == '0));

    assert_pol_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == ADR_POL) |=> (pol_o == $past(wdata_i)));

    assert_rd_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == ADR_EN) |=> (rdata_o == $past(en_o)));
endmodule

// File: rtl/gpio_lvl_irq_gen.sv
module gpio_lvl_irq_gen #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] en_i,
    output logic         irq_o
);
    typedef struct packed {
        logic irq;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic [W-1:0] active;

    always_comb begin
        active    = (sync_i ^ pol_i) & en_i;
        st_d      = st_q;
        st_d.irq  = |active;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    assert_irq_needs_enable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ($past(en_i) != '0));
endmodule

// File: rtl/gpio_lvl_irq_bank.sv
module gpio_lvl_irq_bank
    import gpio_lvl_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                we_i,
    input  logic [NUM_PINS-1:0] wdata_i,
    output logic [NUM_PINS-1:0] rdata_o,
    output logic                irq_o
);
    logic [NUM_PINS-1:0] pins_sync;
    logic [NUM_PINS-1:0] pol;
    logic [NUM_PINS-1:0] en;

    gpio_lvl_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pin_i),
        .sync_o  (pins_sync)
    );

    gpio_lvl_regs #(.W(NUM_PINS)) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pins_i  (pins_sync),
        .addr_i  (addr_i),
        .we_i    (we_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .pol_o   (pol),
        .en_o    (en)
    );

    gpio_lvl_irq_gen #(.W(NUM_PINS)) u_irq (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sync_i (pins_sync),
        .pol_i  (pol),
        .en_i   (en),
        .irq_o  (irq_o)
    );

    assert_idle_after_disable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en == '0) |=> !irq_o);
endmodule

// File: tb/gpio_lvl_irq_bank_tb.sv
module gpio_lvl_irq_bank_tb;
    localparam int N = 8;
    localparam int NV = 9;
    // {pins, polarity, enable, expected irq in bit 0}
    localparam logic [31:0] VEC [NV] = '{
        {8'h00, 8'h00, 8'hFF, 8'h00},
        {8'h01, 8'h00, 8'h01, 8'h01},
        {8'h01, 8'h00, 8'hFE, 8'h00},
        {8'hFF, 8'hFF, 8'hFF, 8'h00},
        {8'hFE, 8'hFF, 8'h01, 8'h01},
        {8'hA5, 8'hA5, 8'hFF, 8'h00},
        {8'hA5, 8'hA4, 8'h0F, 8'h01},
        {8'h80, 8'h00, 8'h7F, 8'h00},
        {8'h80, 8'h00, 8'h80, 8'h01}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] pin = '0;
    logic [2:0] addr = '0;
    logic we = 1'b0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic irq;
    int total = 0;
    int bad = 0;
    logic [N-1:0] v;

    always #5 clk = ~clk;

    gpio_lvl_irq_bank u_dut (
        .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .addr_i(addr),
        .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
        addr = a;
        @(negedge clk);
        d = rdata;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {7'd0, irq}, 8'h00);
        rd(3'd1, v); chk("R1 polarity", v, 8'h00);
        rd(3'd2, v); chk("R1 enable", v, 8'h00);

        // vector table: R3 R4 R7 R2
        for (int i = 0; i < NV; i++) begin
            wr(3'd4, 8'hFF);
            wr(3'd1, VEC[i][23:16]);
            wr(3'd3, VEC[i][15:8]);
            pin = VEC[i][31:24];
            wait_n(4);
            chk("R3/R4 irq", {7'd0, irq}, VEC[i][7:0]);
            rd(3'd1, v); chk("R7 polarity readback", v, VEC[i][23:16]);
            rd(3'd0, v); chk("R2 pin level", v, VEC[i][31:24]);
        end

        // R4 / R2 latency: three edges from pin change to irq
        wr(3'd4, 8'hFF);
        wr(3'd1, 8'h00);
        pin = '0;
        wr(3'd3, 8'h01);
        wait_n(4);
        chk("R4 idle before", {7'd0, irq}, 8'h00);
        pin = 8'h01;
        wait_n(2);
        chk("R4 not yet at edge 2", {7'd0, irq}, 8'h00);
        @(negedge clk);
        chk("R4 high at edge 3", {7'd0, irq}, 8'h01);
        wait_n(5);
        chk("R9 level held", {7'd0, irq}, 8'h01);
        // R9 release
        pin = 8'h00;
        wait_n(2);
        chk("R9 still high at edge 2", {7'd0, irq}, 8'h01);
        @(negedge clk);
        chk("R9 low at edge 3", {7'd0, irq}, 8'h00);

        // R6 disabling an active pin drops irq one edge after write
        pin = 8'h01;
        wait_n(4);
        chk("R6 precondition", {7'd0, irq}, 8'h01);
        wr(3'd4, 8'h01);
        @(negedge clk);
        chk("R6 irq after clear", {7'd0, irq}, 8'h00);

        // R5 / R6 bitwise set and clear
        wr(3'd4, 8'hFF);
        wr(3'd3, 8'h03);
        wr(3'd3, 8'h0C);
        rd(3'd2, v); chk("R5 set keeps zero bits", v, 8'h0F);
        wr(3'd4, 8'h05);
        rd(3'd2, v); chk("R6 clear keeps zero bits", v, 8'h0A);

        // R8 write-only and unmapped addresses read zero
        rd(3'd3, v); chk("R8 set addr reads 0", v, 8'h00);
        rd(3'd4, v); chk("R8 clear addr reads 0", v, 8'h00);
        rd(3'd7, v); chk("R8 unmapped reads 0", v, 8'h00);

        // R10 read data one cycle after address
        addr = 3'd1;
        wr(3'd1, 8'h5A);
        addr = 3'd1;
        @(negedge clk);
        chk("R10 read after address", rdata, 8'h5A);
        addr = 3'd2;
        @(negedge clk);
        chk("R10 switch address", rdata, 8'h0A);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule